// File: doc/BRIEF.md
# Address Translation Front-End and Fault Encoder

This block takes a virtual-address translation request together with the outcome of the TLB lookup for that address. It picks one of four routes. The first is direct physical addressing, used when the global direct mode is on and paging is off. The second is a hit in one of the upper-address windows, gated by privilege. The third is a bad-address fault for a non-canonical address. The last is the TLB-mapped result. The TLB array sits outside the block. Its match or fault code, physical address, permissions and page size come in alongside the request.

A fault produces an exception code that depends on both the TLB fault kind and the access type. An accepted fault, unless it is a probe, also raises a one-cycle exception strobe and updates capture registers. A no-match fault loads the refill capture set and a sticky refill flag. Every other fault loads the bad-address and entry-high registers.

Requests arrive on a valid/ready channel. Responses leave on a valid/ready channel through a single output register. A request is accepted when `req_valid` is high and the output register is empty or is being drained in that same cycle. A response stays stable until the consumer takes it with `rsp_ready`. The mode bits, privilege, window registers, debug hold and refill-done are plain level inputs.

Top module: `atf_front`

## Requirements
- R1: When `mode_da`=1 and `mode_pg`=0, the response has `rsp_pa` = the low PA_W bits of the address, `rsp_perm`=3'b111 (bit2 read, bit1 write, bit0 execute), `rsp_fault`=0 and `rsp_exc`=0.
- R2: Otherwise, window w hits when bits [63:48] of its 64-bit register equal address bits [63:48] and its enable bit for the current level is set. Bit 0 enables `priv`=0 (kernel) and bit 3 enables `priv`=3 (user); levels 1 and 2 never hit. A hit gives the masked address with all three permissions and no fault.
- R3: With no window hit, if address bits [63:48] are neither all zeros nor all ones, the response is a fault with `rsp_exc`=8 (bad address).
- R4: On the mapped route, `tlb_code`=0 (match) gives `rsp_pa`=`tlb_pa`, `rsp_perm`=`tlb_perm` and no fault.
- R5: On the mapped route, `tlb_code`=2 (no match) or 3 (invalid) gives a fault whose code follows `req_acc`: 0 or 3 (load) gives 1, 1 (store) gives 2, 2 (fetch) gives 3. Every fault response has `rsp_pa`=0 and `rsp_perm`=0.
- R6: On the mapped route, `tlb_code` 4 (dirty) gives 4, 5 (read inhibit) gives 5, 6 (execute inhibit) gives 6, 7 (privilege) gives 7, and 1 (bad) gives 8.
- R7: An accepted non-probe no-match fault sets `refill_flag`, loads `refill_badv` with the address and loads `refill_vppn` with address bits [47:13]. The flag stays set until `refill_done` is seen, and a set in the same cycle wins over the clear.
- R8: Any other accepted non-probe fault loads `ehi` with the address with its low `tlb_ps`+1 bits cleared (zero when `tlb_ps`=63). It also loads `badv` with the address unless `dbg_hold`=1.
- R9: An accepted non-probe fault pulses `exc_strobe` for exactly one cycle, in the cycle its response first shows. `exc_code` then holds that fault's code until the next strobe.
- R10: `req_ready` = !`rsp_valid` || `rsp_ready`. A response that is not taken keeps all its fields unchanged.
- R11: A probe request (`req_probe`=1) still returns its fault code but raises no strobe and changes none of the capture registers or the refill flag.
- R12: After reset every output register reads zero and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_da | input | 1 | Global direct-address mode |
| mode_pg | input | 1 | Paging enable |
| priv | input | 2 | Current privilege level (0 kernel, 3 user) |
| win_cfg | input | 256 | Four 64-bit window registers, window w at [64w+63:64w] |
| dbg_hold | input | 1 | Debug hold: blocks `badv` updates |
| refill_done | input | 1 | Clears the refill flag |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | 64 | Virtual address |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 load |
| req_probe | input | 1 | Probe: no strobe, no capture |
| tlb_code | input | 3 | TLB outcome code for this address |
| tlb_pa | input | 48 | TLB physical address on match |
| tlb_perm | input | 3 | TLB permissions on match |
| tlb_ps | input | 6 | Page size exponent of the entry |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_pa | output | 48 | Physical address |
| rsp_perm | output | 3 | Read/write/execute grant |
| rsp_fault | output | 1 | Response is a fault |
| rsp_exc | output | 6 | Exception code, 0 if none |
| exc_strobe | output | 1 | One-cycle exception pulse |
| exc_code | output | 6 | Code of the latest strobe |
| refill_flag | output | 1 | Refill in progress |
| refill_badv | output | 64 | Refill bad address |
| refill_vppn | output | 35 | Refill virtual page-pair number |
| badv | output | 64 | Bad address of last non-refill fault |
| ehi | output | 64 | Entry-high capture |

## Verification
The stimulus mixes the upper address bits across every window segment, the two canonical patterns and one non-canonical pattern, under all four privilege levels. This separates window hits from privilege misses and from canonical and bad-address fall-through. Paging and direct-mode bits are toggled so that the direct route must take priority over a window that would also hit. All eight TLB codes are crossed with all four access types to separate the invalid-page codes per access and the fixed codes for the other fault kinds. Probe, debug hold, refill-done and consumer stalls are applied independently, and page sizes include 63, which shows whether captures are suppressed, whether the refill flag is sticky and whether responses hold under back-pressure.

// File: rtl/atf_pkg.sv
package atf_pkg;

  typedef enum logic [2:0] {
    TC_MATCH   = 3'd0,
    TC_BAD     = 3'd1,
    TC_NOMATCH = 3'd2,
    TC_INVALID = 3'd3,
    TC_DIRTY   = 3'd4,
    TC_NOREAD  = 3'd5,
    TC_NOEXEC  = 3'd6,
    TC_PRIV    = 3'd7
  } tlb_code_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int EXC_W = 6;

  typedef enum logic [EXC_W-1:0] {
    EXC_NONE     = 6'd0,
    EXC_INV_LD   = 6'd1,
    EXC_INV_ST   = 6'd2,
    EXC_INV_IF   = 6'd3,
    EXC_MODIFY   = 6'd4,
    EXC_NOREAD   = 6'd5,
    EXC_NOEXEC   = 6'd6,
    EXC_PRIVILL  = 6'd7,
    EXC_BADADDR  = 6'd8
  } exc_e;

  localparam logic [2:0] PERM_ALL = 3'b111;

endpackage

// File: rtl/atf_window_match.sv
module atf_window_match #(
  parameter int ADDR_W   = 64,
  parameter int VA_W     = 48,
  parameter int NUM_WIN  = 4,
  parameter int KERN_BIT = 0,
  parameter int USER_BIT = 3
) (
  input  logic [NUM_WIN*ADDR_W-1:0] win_cfg,
  input  logic [1:0]                priv,
  input  logic [ADDR_W-1:0]         addr,
  output logic                      hit
);
  localparam int HI_W = ADDR_W - VA_W;

  logic [ADDR_W-1:0]  lvl_mask;
  logic [NUM_WIN-1:0] hit_vec;

  always_comb begin
    lvl_mask           = '0;
    lvl_mask[KERN_BIT] = (priv == 2'd0);
    lvl_mask[USER_BIT] = (priv == 2'd3);
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [ADDR_W-1:0] reg_w;
    logic              en_w;
    logic              seg_eq;
    assign reg_w   = win_cfg[w*ADDR_W +: ADDR_W];
    assign en_w    = |(reg_w & lvl_mask);
    assign seg_eq  = (reg_w[ADDR_W-1 -: HI_W] == addr[ADDR_W-1 -: HI_W]);
    assign hit_vec[w] = en_w && seg_eq;
  end

  assign hit = |hit_vec;

endmodule

// File: rtl/atf_fault_encoder.sv
module atf_fault_encoder
  import atf_pkg::*;
(
  input  logic [2:0]       tlb_code,
  input  logic [1:0]       acc,
  output logic             is_fault,
  output logic             is_refill,
  output logic [EXC_W-1:0] exc
);
  exc_e inv_code;

  always_comb begin
    unique case (acc_e'(acc))
      ACC_STORE: inv_code = EXC_INV_ST;
      ACC_FETCH: inv_code = EXC_INV_IF;
      default:   inv_code = EXC_INV_LD;
    endcase
  end

  always_comb begin
    is_fault  = 1'b1;
    is_refill = 1'b0;
    unique case (tlb_code_e'(tlb_code))
      TC_MATCH: begin
        is_fault = 1'b0;
        exc      = EXC_NONE;
      end
      TC_NOMATCH: begin
        is_refill = 1'b1;
        exc       = inv_code;
      end
      TC_INVALID: exc = inv_code;
      TC_DIRTY:   exc = EXC_MODIFY;
      TC_NOREAD:  exc = EXC_NOREAD;
      TC_NOEXEC:  exc = EXC_NOEXEC;
      TC_PRIV:    exc = EXC_PRIVILL;
      default:    exc = EXC_BADADDR;
    endcase
  end

endmodule

// File: rtl/atf_path_select.sv
module atf_path_select
  import atf_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int VA_W   = 48,
  parameter int PA_W   = 48
) (
  input  logic              mode_da,
  input  logic              mode_pg,
  input  logic              win_hit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        acc,
  input  logic [2:0]        tlb_code,
  input  logic [PA_W-1:0]   tlb_pa,
  input  logic [2:0]        tlb_perm,
  output logic [PA_W-1:0]   pa,
  output logic [2:0]        perm,
  output logic              fault,
  output logic              refill,
  output logic [EXC_W-1:0]  exc
);
  localparam int HI_W = ADDR_W - VA_W;

  logic             direct_on;
  logic             canon;
  logic             enc_fault;
  logic             enc_refill;
  logic [EXC_W-1:0] enc_exc;

  assign direct_on = mode_da && !mode_pg;
  assign canon     = (addr[ADDR_W-1 -: HI_W] == '0) || (addr[ADDR_W-1 -: HI_W] == '1);

  atf_fault_encoder u_enc (
    .tlb_code  (tlb_code),
    .acc       (acc),
    .is_fault  (enc_fault),
    .is_refill (enc_refill),
    .exc       (enc_exc)
  );

  always_comb begin
    pa     = '0;
    perm   = '0;
    fault  = 1'b0;
    refill = 1'b0;
    exc    = EXC_NONE;
    if (direct_on || win_hit) begin
      pa   = addr[PA_W-1:0];
      perm = PERM_ALL;
    end else if (!canon) begin
      fault = 1'b1;
      exc   = EXC_BADADDR;
    end else if (!enc_fault) begin
      pa   = tlb_pa;
      perm = tlb_perm;
    end else begin
      fault  = 1'b1;
      refill = enc_refill;
      exc    = enc_exc;
    end
  end

endmodule

// File: rtl/atf_capture.sv
module atf_capture #(
  parameter int ADDR_W   = 64,
  parameter int VA_W     = 48,
  parameter int PS_W     = 6,
  parameter int VPPN_LSB = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fire,
  input  logic                     is_refill,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [PS_W-1:0]          ps,
  input  logic                     dbg_hold,
  input  logic                     refill_done,
  output logic                     refill_flag,
  output logic [ADDR_W-1:0]        refill_badv,
  output logic [VA_W-VPPN_LSB-1:0] refill_vppn,
  output logic [ADDR_W-1:0]        badv,
  output logic [ADDR_W-1:0]        ehi
);
  localparam int VPPN_W = VA_W - VPPN_LSB;

  logic [PS_W:0]     low_bits;
  logic [ADDR_W-1:0] keep_mask;
  logic              refill_ev;
  logic              other_ev;

  assign low_bits  = {1'b0, ps} + 1'b1;
  assign keep_mask = ~(({{(ADDR_W-1){1'b0}}, 1'b1} << low_bits) - 1'b1);
  assign refill_ev = fire && is_refill;
  assign other_ev  = fire && !is_refill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refill_flag <= 1'b0;
      refill_badv <= '0;
      refill_vppn <= '0;
      badv        <= '0;
      ehi         <= '0;
    end else begin
      if (refill_ev) begin
        refill_flag <= 1'b1;
        refill_badv <= addr;
        refill_vppn <= addr[VPPN_LSB +: VPPN_W];
      end else if (refill_done) begin
        refill_flag <= 1'b0;
      end
      if (other_ev) begin
        ehi <= addr & keep_mask;
        if (!dbg_hold) badv <= addr;
      end
    end
  end

endmodule

// File: rtl/atf_front.sv
module atf_front
  import atf_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int VA_W     = 48,
  parameter int PA_W     = 48,
  parameter int NUM_WIN  = 4,
  parameter int PS_W     = 6,
  parameter int VPPN_LSB = 13,
  parameter int KERN_BIT = 0,
  parameter int USER_BIT = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mode_da,
  input  logic                      mode_pg,
  input  logic [1:0]                priv,
  input  logic [NUM_WIN*ADDR_W-1:0] win_cfg,
  input  logic                      dbg_hold,
  input  logic                      refill_done,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [1:0]                req_acc,
  input  logic                      req_probe,
  input  logic [2:0]                tlb_code,
  input  logic [PA_W-1:0]           tlb_pa,
  input  logic [2:0]                tlb_perm,
  input  logic [PS_W-1:0]           tlb_ps,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [PA_W-1:0]           rsp_pa,
  output logic [2:0]                rsp_perm,
  output logic                      rsp_fault,
  output logic [EXC_W-1:0]          rsp_exc,
  output logic                      exc_strobe,
  output logic [EXC_W-1:0]          exc_code,
  output logic                      refill_flag,
  output logic [ADDR_W-1:0]         refill_badv,
  output logic [VA_W-VPPN_LSB-1:0]  refill_vppn,
  output logic [ADDR_W-1:0]         badv,
  output logic [ADDR_W-1:0]         ehi
);
  logic             win_hit;
  logic [PA_W-1:0]  sel_pa;
  logic [2:0]       sel_perm;
  logic             sel_fault;
  logic             sel_refill;
  logic [EXC_W-1:0] sel_exc;
  logic             accept;
  logic             fire;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign fire      = accept && sel_fault && !req_probe;

  atf_window_match #(
    .ADDR_W   (ADDR_W),
    .VA_W     (VA_W),
    .NUM_WIN  (NUM_WIN),
    .KERN_BIT (KERN_BIT),
    .USER_BIT (USER_BIT)
  ) u_win (
    .win_cfg (win_cfg),
    .priv    (priv),
    .addr    (req_addr),
    .hit     (win_hit)
  );

  atf_path_select #(
    .ADDR_W (ADDR_W),
    .VA_W   (VA_W),
    .PA_W   (PA_W)
  ) u_sel (
    .mode_da  (mode_da),
    .mode_pg  (mode_pg),
    .win_hit  (win_hit),
    .addr     (req_addr),
    .acc      (req_acc),
    .tlb_code (tlb_code),
    .tlb_pa   (tlb_pa),
    .tlb_perm (tlb_perm),
    .pa       (sel_pa),
    .perm     (sel_perm),
    .fault    (sel_fault),
    .refill   (sel_refill),
    .exc      (sel_exc)
  );

  atf_capture #(
    .ADDR_W   (ADDR_W),
    .VA_W     (VA_W),
    .PS_W     (PS_W),
    .VPPN_LSB (VPPN_LSB)
  ) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .is_refill   (sel_refill),
    .addr        (req_addr),
    .ps          (tlb_ps),
    .dbg_hold    (dbg_hold),
    .refill_done (refill_done),
    .refill_flag (refill_flag),
    .refill_badv (refill_badv),
    .refill_vppn (refill_vppn),
    .badv        (badv),
    .ehi         (ehi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_pa     <= '0;
      rsp_perm   <= '0;
      rsp_fault  <= 1'b0;
      rsp_exc    <= '0;
      exc_strobe <= 1'b0;
      exc_code   <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_pa    <= sel_pa;
        rsp_perm  <= sel_perm;
        rsp_fault <= sel_fault;
        rsp_exc   <= sel_exc;
      end
      exc_strobe <= fire;
      if (fire) exc_code <= sel_exc;
    end
  end

endmodule

// File: rtl/atf_front_chk.sv
module atf_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_probe,
  input logic        refill_done,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [47:0] rsp_pa,
  input logic [2:0]  rsp_perm,
  input logic        rsp_fault,
  input logic [5:0]  rsp_exc,
  input logic        exc_strobe,
  input logic [5:0]  exc_code,
  input logic        refill_flag
);
  AST_FAULT_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_exc != 6'd0 && rsp_perm == 3'b000); // R5

  AST_CLEAN_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_exc == 6'd0); // R4

  AST_STROBE_WITH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    exc_strobe |-> rsp_valid && rsp_fault && exc_code == rsp_exc); // R9

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_strobe && !req_ready |=> !exc_strobe); // R9

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_exc)
      && $stable(rsp_perm) && $stable(rsp_fault)); // R10

  AST_REFILL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    refill_flag && !refill_done |=> refill_flag); // R7

  AST_PROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_probe |=> !exc_strobe); // R11

endmodule

bind atf_front atf_front_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_probe   (req_probe),
  .refill_done (refill_done),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_pa      (rsp_pa),
  .rsp_perm    (rsp_perm),
  .rsp_fault   (rsp_fault),
  .rsp_exc     (rsp_exc),
  .exc_strobe  (exc_strobe),
  .exc_code    (exc_code),
  .refill_flag (refill_flag)
);

// File: tb/atf_front_test.sv
module atf_front_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_da = 1'b0, mode_pg = 1'b1;
  logic [1:0]   priv = 2'd0;
  logic [255:0] win_cfg;
  logic         dbg_hold = 1'b0, refill_done = 1'b0;
  logic         req_valid = 1'b0, req_probe = 1'b0, rsp_ready = 1'b0;
  logic [63:0]  req_addr = '0;
  logic [1:0]   req_acc = '0;
  logic [2:0]   tlb_code = '0, tlb_perm = '0;
  logic [47:0]  tlb_pa = '0;
  logic [5:0]   tlb_ps = '0;
  logic         req_ready, rsp_valid, rsp_fault, exc_strobe, refill_flag;
  logic [47:0]  rsp_pa;
  logic [2:0]   rsp_perm;
  logic [5:0]   rsp_exc, exc_code;
  logic [63:0]  refill_badv, badv, ehi;
  logic [34:0]  refill_vppn;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  atf_front uut (
    .clk(clk), .rst_n(rst_n), .mode_da(mode_da), .mode_pg(mode_pg), .priv(priv),
    .win_cfg(win_cfg), .dbg_hold(dbg_hold), .refill_done(refill_done),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_acc(req_acc), .req_probe(req_probe), .tlb_code(tlb_code), .tlb_pa(tlb_pa),
    .tlb_perm(tlb_perm), .tlb_ps(tlb_ps), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_pa(rsp_pa), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault), .rsp_exc(rsp_exc),
    .exc_strobe(exc_strobe), .exc_code(exc_code), .refill_flag(refill_flag),
    .refill_badv(refill_badv), .refill_vppn(refill_vppn), .badv(badv), .ehi(ehi)
  );

  // window 0: segment 9000, kernel; window 1: segment 8000, user;
  // window 2: segment A000, both; window 3: disabled
  logic [63:0] wr [4];
  initial begin
    wr[0] = 64'h9000_0000_0000_0001;
    wr[1] = 64'h8000_0000_0000_0008;
    wr[2] = 64'hA000_0000_0000_0009;
    wr[3] = 64'h1234_0000_0000_0000;
  end
  assign win_cfg = {wr[3], wr[2], wr[1], wr[0]};

  // reference model state
  logic        m_valid = 0, m_fault = 0, m_strobe = 0, m_rflag = 0;
  logic [47:0] m_pa = 0;
  logic [2:0]  m_perm = 0;
  logic [5:0]  m_exc = 0, m_code = 0;
  logic [63:0] m_rbadv = 0, m_badv = 0, m_ehi = 0;
  logic [34:0] m_rvppn = 0;
  string       m_tag = "R12";
  string       m_ctag = "R12";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_fault = 0; m_strobe = 0; m_rflag = 0; m_pa = 0; m_perm = 0;
      m_exc = 0; m_code = 0; m_rbadv = 0; m_badv = 0; m_ehi = 0; m_rvppn = 0;
      m_tag = "R12"; m_ctag = "R12";
    end else begin
      bit acc, hit, refill;
      logic [63:0] lvl;
      logic [15:0] top;
      acc = req_valid && (!m_valid || rsp_ready);
      if (m_valid && rsp_ready) m_valid = 0;
      m_strobe = 0;
      if (refill_done) m_rflag = 0;
      if (acc) begin
        refill = 0;
        m_valid = 1; m_pa = 0; m_perm = 0; m_fault = 0; m_exc = 0;
        top = req_addr[63:48];
        lvl = 0;
        if (priv == 0) lvl[0] = 1;
        if (priv == 3) lvl[3] = 1;
        hit = 0;
        for (int w = 0; w < 4; w++)
          if ((wr[w] & lvl) != 0 && wr[w][63:48] == top) hit = 1;
        if (mode_da && !mode_pg) begin
          m_pa = req_addr[47:0]; m_perm = 7; m_tag = "R1";
        end else if (hit) begin
          m_pa = req_addr[47:0]; m_perm = 7; m_tag = "R2";
        end else if (top != 16'h0000 && top != 16'hFFFF) begin
          m_fault = 1; m_exc = 8; m_tag = "R3";
        end else if (tlb_code == 0) begin
          m_pa = tlb_pa; m_perm = tlb_perm; m_tag = "R4";
        end else if (tlb_code == 2 || tlb_code == 3) begin
          m_fault = 1; m_tag = "R5";
          m_exc = (req_acc == 1) ? 6'd2 : (req_acc == 2) ? 6'd3 : 6'd1;
          refill = (tlb_code == 2);
        end else begin
          m_fault = 1; m_tag = "R6";
          m_exc = (tlb_code == 1) ? 6'd8 : {3'd0, tlb_code};
        end
        m_ctag = req_probe ? "R11" : (refill ? "R7" : "R8");
        if (m_fault && !req_probe) begin
          m_strobe = 1; m_code = m_exc;
          if (refill) begin
            m_rflag = 1; m_rbadv = req_addr; m_rvppn = req_addr[47:13];
          end else begin
            int sh;
            sh = tlb_ps + 1;
            m_ehi = (sh >= 64) ? 64'd0 : (req_addr & ~((64'd1 << sh) - 64'd1));
            if (!dbg_hold) m_badv = req_addr;
          end
        end
      end
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R10", "req_ready", 64'(req_ready), 64'(!m_valid || rsp_ready));
    chk("R10", "rsp_valid", 64'(rsp_valid), 64'(m_valid));
    if (m_valid) begin
      chk(m_tag, "rsp_pa", 64'(rsp_pa), 64'(m_pa));
      chk(m_tag, "rsp_perm", 64'(rsp_perm), 64'(m_perm));
      chk(m_tag, "rsp_fault", 64'(rsp_fault), 64'(m_fault));
      chk(m_tag, "rsp_exc", 64'(rsp_exc), 64'(m_exc));
    end
    chk("R9", "exc_strobe", 64'(exc_strobe), 64'(m_strobe));
    chk("R9", "exc_code", 64'(exc_code), 64'(m_code));
    chk(m_ctag == "R11" ? "R11" : "R7", "refill_flag", 64'(refill_flag), 64'(m_rflag));
    chk(m_ctag == "R11" ? "R11" : "R7", "refill_badv", refill_badv, m_rbadv);
    chk(m_ctag == "R11" ? "R11" : "R7", "refill_vppn", 64'(refill_vppn), 64'(m_rvppn));
    chk(m_ctag == "R11" ? "R11" : "R8", "badv", badv, m_badv);
    chk(m_ctag == "R11" ? "R11" : "R8", "ehi", ehi, m_ehi);
  endtask

  function automatic logic [15:0] pick_top(int k);
    case (k)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h9000;
      3: return 16'h8000;
      4: return 16'hA000;
      5: return 16'h1234;
      default: return 16'h0001;
    endcase
  endfunction

  function automatic logic [5:0] pick_ps(int k);
    case (k)
      0: return 6'd12;
      1: return 6'd13;
      2: return 6'd14;
      3: return 6'd21;
      4: return 6'd0;
      default: return 6'd63;
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "rsp_valid", 64'(rsp_valid), 0);
    chk("R12", "req_ready", 64'(req_ready), 1);
    chk("R12", "exc_strobe", 64'(exc_strobe), 0);
    chk("R12", "refill_flag", 64'(refill_flag), 0);
    chk("R12", "badv", badv, 0);
    chk("R12", "ehi", ehi, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      compare_all();
      req_valid   = ($urandom % 4) != 0;
      rsp_ready   = ($urandom % 4) != 0;
      mode_da     = ($urandom % 4) == 0;
      mode_pg     = ($urandom % 2) == 0;
      priv        = 2'($urandom % 4);
      dbg_hold    = ($urandom % 4) == 0;
      refill_done = ($urandom % 8) == 0;
      req_probe   = ($urandom % 6) == 0;
      req_acc     = 2'($urandom % 4);
      req_addr    = {pick_top($urandom % 7), 16'($urandom), 32'($urandom)};
      tlb_code    = 3'($urandom % 8);
      tlb_pa      = {16'($urandom), 32'($urandom)};
      tlb_perm    = 3'($urandom % 8);
      tlb_ps      = pick_ps($urandom % 6);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    repeat (3) begin
      @(negedge clk);
      compare_all();
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule